// File: doc/BRIEF.md
# Reloading Timer/Event Counter

An 8-bit up-counter that can count either a divided internal clock or transitions on an external pin. The prescaler in front of the counter has seven binary stages, so the internal clock can be divided by any power of two from 1 to 128. When the counter steps past its all-ones value it takes the value held in a separate preload register and keeps running. This gives a repeating period that software sets by writing the preload value.

Software sees three locations on a small word-wide bus: the preload value, a control word and the live count. The control word starts and stops counting, picks timer or event mode, picks the active edge of the event pin, picks the divider and enables the overflow request. Its top bit reads back a sticky overflow flag, which also drives the interrupt request output. The event pin is resynchronised to the clock and edge-detected before it reaches the counter.

Top module: `reload_tmr`

## Requirements
- R1: After reset the preload, control and count locations all read 00H and irq_o is low.
- R2: With control bit 4 (run) set and bit 5 (mode) clear, the count steps by one every 2^k clocks, where k is control bits 2:0. The first step falls on the 2^k-th clock edge after the edge that sets run.
- R3: While run is clear the count holds its value; only a preload write changes it.
- R4: A step from FFH loads the current preload value instead of 00H, and counting continues.
- R5: With a preload of 00H the counter passes through all 256 values between reloads.
- R6: A step from FFH sets the overflow flag (control bit 7, and irq_o) only if control bit 6 (interrupt enable) is set. With bit 6 clear the flag stays low.
- R7: The flag stays set until a control write with bit 7 = 0. A control write with bit 7 = 1 leaves the flag unchanged.
- R8: With bit 5 set, each edge of evt_i steps the count once. Bit 3 = 0 selects rising edges and bit 3 = 1 selects falling edges. The count changes on the second clock edge after the input edge is first sampled. A steady level has no effect.
- R9: A preload write while run is clear also loads the count. A preload write while run is set changes only the preload location.
- R10: Addresses: 0 = preload (read/write), 1 = control (read/write), 2 = count (read only). rdata_o is combinational from addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i |
| evt_i | input | 1 | External event input, asynchronous |
| irq_o | output | 1 | Sticky overflow request |

## Verification
The bench builds the block at its default 8-bit width with the full seven-stage prescaler. It sweeps all eight divider settings, with a different preload value for each, and runs each one long enough to wrap at least once. That makes the step rate, the floor of the divided count, the reload value and the interrupt-enable gating checkable against an arithmetic model in every setting. Event mode is driven with clean pulses under both edge selections, including an overflow, and a held level to show that the level itself is ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    A_PRELOAD = 2'd0,
    A_CTRL    = 2'd1,
    A_COUNT   = 2'd2
  } tmr_addr_e;

  localparam int unsigned B_EDGE = 3;
  localparam int unsigned B_RUN  = 4;
  localparam int unsigned B_MODE = 5;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_FLAG = 7;
  localparam int unsigned CTRL_W = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned STAGES = 7,
  localparam int unsigned SEL_W = $clog2(STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [STAGES-1:0] psc_q;
  logic [STAGES:0]   tap;

  assign tap[0] = 1'b1;
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign tap[k] = &psc_q[k-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (!en_i) psc_q <= '0;
    else            psc_q <= psc_q + 1'b1;
  end

  assign tick_o = en_i & tap[sel_i];
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [SYNC:0] sh_q;
  logic cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], d_i};
  end

  assign cur    = sh_q[SYNC-1];
  assign prev   = sh_q[SYNC];
  assign edge_o = fall_i ? (~cur & prev) : (cur & ~prev);
endmodule

// File: rtl/reload_tmr.sv
module reload_tmr
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PSC_STAGES = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             evt_i,
  output logic             irq_o
);
  localparam int unsigned SEL_W = $clog2(PSC_STAGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q, preload_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q;
  logic              run, ie, evt_mode, tick, evt_edge, inc, wrap;
  logic              wr_pre, wr_ctl;

  assign run      = ctrl_q[B_RUN];
  assign ie       = ctrl_q[B_IE];
  assign evt_mode = ctrl_q[B_MODE];

  tmr_prescaler #(.STAGES(PSC_STAGES)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run & ~evt_mode),
    .sel_i  (ctrl_q[SEL_W-1:0]),
    .tick_o (tick)
  );

  tmr_edge_sync #(.SYNC(2)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (evt_i),
    .fall_i (ctrl_q[B_EDGE]),
    .edge_o (evt_edge)
  );

  assign inc    = run & (evt_mode ? evt_edge : tick);
  assign wrap   = inc & (cnt_q == CNT_MAX);
  assign wr_pre = wr_en_i & (addr_i == A_PRELOAD);
  assign wr_ctl = wr_en_i & (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preload_q <= '0;
      ctrl_q    <= '0;
    end else begin
      if (wr_pre) preload_q <= wdata_i;
      if (wr_ctl) ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  // stopped preload write seeds the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (wr_pre && !run)  cnt_q <= wdata_i;
    else if (wrap)            cnt_q <= preload_q;
    else if (inc)             cnt_q <= cnt_q + 1'b1;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= 1'b0;
    else if (wrap && ie)                flag_q <= 1'b1;
    else if (wr_ctl && !wdata_i[B_FLAG]) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PRELOAD: rdata_o = preload_q;
      A_CTRL:    rdata_o[CTRL_W:0] = {flag_q, ctrl_q};
      A_COUNT:   rdata_o = cnt_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/reload_tmr_chk.sv
module reload_tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preload_q,
  input logic             run,
  input logic             ie,
  input logic             inc,
  input logic             flag_q,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !(wr_en_i && addr_i == A_PRELOAD)) |=> $stable(cnt_q)); // R3

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && cnt_q == CNT_MAX) |=> cnt_q == $past(preload_q)); // R4

  AST_NO_FLAG_IE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !(inc && cnt_q == CNT_MAX && ie)) |=> !irq_o); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_en_i && addr_i == A_CTRL && !wdata_i[B_FLAG])) |=> irq_o); // R7
endmodule

bind reload_tmr reload_tmr_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_reload_tmr.sv
module sim_reload_tmr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       evt = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] RUN = 8'h10, MODE = 8'h20, IE = 8'h40, FALL = 8'h08, KEEP = 8'h80;

  always #4 clk = ~clk;

  reload_tmr u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse();
    evt = 1'b1;
    repeat (4) @(negedge clk);
    evt = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] model(input logic [7:0] p, input int steps, output bit ovf);
    logic [7:0] c = p;
    ovf = 1'b0;
    for (int i = 0; i < steps; i++) begin
      if (c == 8'hFF) begin c = p; ovf = 1'b1; end
      else c = c + 8'd1;
    end
    return c;
  endfunction

  task automatic finish_sim();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      finish_sim();
    end
  end

  initial begin
    logic [7:0] v, v0, p, e;
    bit ovf;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 preload", v, 0);
    rd(2'd1, v); check("R1 ctrl", v, 0);
    rd(2'd2, v); check("R1 count", v, 0);
    check("R1 irq", irq, 0);

    // R2/R4/R6/R3 sweep over divider settings
    for (int k = 0; k < 8; k++) begin
      p = 8'(k * 37);
      wr(2'd1, 8'h00);
      wr(2'd0, p);
      rd(2'd2, v); check("R9 stopped preload loads count", v, p);
      wr(2'd1, RUN | ((k % 2 == 1) ? IE : 8'h00) | 8'(k));
      n = ((256 - int'(p) + 5 + k) << k) + (k % 3);
      repeat (n) @(negedge clk);
      e = model(p, n >> k, ovf);
      rd(2'd2, v); check($sformatf("R2 R4 count k=%0d", k), v, e);
      rd(2'd1, v); check($sformatf("R6 flag k=%0d", k), v[7], (k % 2 == 1) && ovf);
      check($sformatf("R6 irq k=%0d", k), irq, (k % 2 == 1) && ovf);
      wr(2'd1, KEEP);
      check($sformatf("R7 keep flag k=%0d", k), irq, (k % 2 == 1) && ovf);
      rd(2'd2, v0);
      repeat (20) @(negedge clk);
      rd(2'd2, v); check($sformatf("R3 hold k=%0d", k), v, v0);
    end
    wr(2'd1, 8'h00);
    check("R7 clear flag", irq, 0);

    // R5 full range with preload 0
    wr(2'd0, 8'h00);
    wr(2'd1, RUN | IE);
    repeat (255) @(negedge clk);
    rd(2'd2, v); check("R5 count at FF", v, 255);
    check("R5 no flag yet", irq, 0);
    @(negedge clk);
    rd(2'd2, v); check("R5 wraps to 00", v, 0);
    check("R5 flag on wrap", irq, 1);

    // R9 preload write while running
    repeat (4) @(negedge clk);
    wr(2'd0, 8'd200);
    rd(2'd2, v); check("R9 running count untouched", v, 5);
    rd(2'd0, v); check("R9 preload updated", v, 200);
    wr(2'd1, KEEP);
    rd(2'd2, v); check("R9 count at stop", v, 6);
    wr(2'd0, 8'd77);
    rd(2'd2, v); check("R9 stopped load", v, 77);
    wr(2'd1, 8'h00);

    // R8 event mode, rising edges
    wr(2'd0, 8'd10);
    wr(2'd1, RUN | MODE);
    for (int i = 0; i < 5; i++) pulse();
    rd(2'd2, v); check("R8 rising edges", v, 15);
    wr(2'd1, RUN | MODE | FALL);
    for (int i = 0; i < 3; i++) pulse();
    rd(2'd2, v); check("R8 falling edges", v, 18);
    evt = 1'b1;
    repeat (30) @(negedge clk);
    rd(2'd2, v); check("R8 level ignored", v, 18);
    evt = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R8 falling edge counted", v, 19);

    // event mode wrap with reload
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd254);
    wr(2'd1, RUN | MODE | IE);
    pulse(); pulse();
    rd(2'd2, v); check("R4 event reload", v, 254);
    pulse();
    rd(2'd2, v); check("R4 event continue", v, 255);
    check("R6 event flag", irq, 1);
    rd(2'd3, v); check("R10 unused address", v, 0);

    done = 1'b1;
    finish_sim();
  end
endmodule